// File: doc/BRIEF.md
# Stereo PCM Serial Port (Target Mode, Four Framings)

This block is the digital serial front of a stereo converter pair. It runs as a target: the bit clock and the left/right word clock are driven by an external source. The block oversamples both clocks with its own system clock. It deserializes the converter-bound (DAC) stream from a data input and presents each left/right pair on parallel outputs with a single-cycle strobe. It also serializes a parallel converter-sourced (ADC) pair onto the data output.

A 2-bit format code selects one of four framings, and the two directions are not always framed the same way. Codes 0 and 1 receive right-justified words of 16 and 20 bits and transmit left-justified words of the same length. Code 2 is left-justified with 20 bits in both directions. Code 3 is I2S: words start one bit clock after the word-clock edge, with 20 bits received and 18 bits sent. A polarity input swaps which word-clock level means "left" in codes 0 to 2. A half-frame may hold 16, 24 or 32 bit clocks. All parallel samples are 20 bits wide and MSB-aligned.

Top module: `aud_sport_top`

## Requirements
- R1: During and directly after a synchronous reset, `dac_valid_o` is 0, both DAC sample outputs are 0 and `sdout_o` is 0.
- R2: Format 0 captures the last 16 bits before each word-clock edge (right-justified, MSB first) and presents them as `{word,4'b0}`.
- R3: Format 1 captures the last 20 bits before each word-clock edge, MSB first.
- R4: Format 2 captures the first 20 bits after each word-clock edge, MSB first.
- R5: Format 3 captures the 20 bits that start in the second bit slot after each word-clock edge. In this format the left channel is word clock low, whatever the polarity input.
- R6: In formats 0 to 2 the transmit word starts in the first bit slot of its half-frame, MSB first: bits [19:4] for format 0, bits [19:0] for formats 1 and 2.
- R7: In format 3 the transmit word is ADC bits [19:2], starting in the second bit slot of the half-frame. The first slot carries 0.
- R8: With polarity 0 the left channel is word clock high. With polarity 1 it is word clock low (formats 0 to 2).
- R9: Half-frames of 16, 24 and 32 bit clocks (32, 48, 64 per frame) work for every format legal at that length. Only format 0 is legal at 32.
- R10: A received pair raises `dac_valid_o` for exactly one cycle once the right word completes. The DAC sample outputs change only in that cycle.
- R11: The ADC pair is latched when the left half-frame begins. Changes to the ADC inputs later in that frame do not reach `sdout_o` until the next frame.
- R12: Receive bit slots outside the word window are ignored, and transmit slots outside the word window carry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the serial pins |
| rst_i | input | 1 | Synchronous active-high reset |
| bclk_i | input | 1 | External bit clock |
| wclk_i | input | 1 | External left/right word clock |
| sdin_i | input | 1 | Serial DAC data, sampled on bit-clock rise |
| fmt_i | input | 2 | Framing code 0..3 |
| lr_pol_i | input | 1 | Word-clock polarity select |
| adc_left_i | input | 20 | Left ADC sample, MSB-aligned |
| adc_right_i | input | 20 | Right ADC sample, MSB-aligned |
| sdout_o | output | 1 | Serial ADC data, updated after bit-clock fall or word-clock edge |
| dac_left_o | output | 20 | Received left sample, MSB-aligned |
| dac_right_o | output | 20 | Received right sample, MSB-aligned |
| dac_valid_o | output | 1 | One-cycle strobe for a new received pair |

## Verification
Some properties are checked on every cycle: the strobe is always a single cycle, the received samples hold still between strobes, the output line is quiet after reset, and the transmit line is 0 in the I2S lead slot and past the 20th slot. The bench scenarios cover the rest. Only they show that the right bits are chosen from a half-frame in each format, frame length and polarity. They also show that garbage in unused receive slots is discarded and that an ADC change in mid-frame is deferred to the next frame.

// File: rtl/aud_sport_pkg.sv
package aud_sport_pkg;

    localparam int SAMPLE_W = 20;
    localparam int SHREG_W  = 32;
    localparam int POS_W    = 6;
    localparam int IDX_W    = $clog2(SAMPLE_W);
    localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

    typedef enum logic [1:0] {
        FMT_RJ16 = 2'd0,
        FMT_RJ20 = 2'd1,
        FMT_LJ20 = 2'd2,
        FMT_I2S  = 2'd3
    } fmt_e;

    // Pin samples and edge events seen in one system clock
    typedef struct packed {
        logic bclk_rise;
        logic bclk_fall;
        logic wclk;
        logic wclk_chg;
        logic din;
    } pin_evt_t;

    typedef struct packed {
        logic [SAMPLE_W-1:0] left;
        logic [SAMPLE_W-1:0] right;
    } stereo_t;

    function automatic logic chan_is_left(fmt_e f, logic pol, logic wclk);
        return (f == FMT_I2S) ? !wclk : (wclk ^ !pol) ? 1'b0 : 1'b1;
    endfunction

    function automatic logic [POS_W-1:0] tx_off(fmt_e f);
        return (f == FMT_I2S) ? POS_W'(1) : POS_W'(0);
    endfunction

    function automatic logic [POS_W-1:0] tx_len(fmt_e f);
        case (f)
            FMT_RJ16: return POS_W'(16);
            FMT_I2S:  return POS_W'(18);
            default:  return POS_W'(SAMPLE_W);
        endcase
    endfunction

endpackage

// File: rtl/aud_sport_pins.sv
module aud_sport_pins
    import aud_sport_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     bclk,
    input  logic     wclk,
    input  logic     din,
    output pin_evt_t evt
);
    logic b1, b2, w1, w2, d1;

    always_ff @(posedge clk) begin
        if (rst) begin
            b1 <= 1'b0; b2 <= 1'b0;
            w1 <= 1'b0; w2 <= 1'b0;
            d1 <= 1'b0;
        end else begin
            b1 <= bclk; b2 <= b1;
            w1 <= wclk; w2 <= w1;
            d1 <= din;
        end
    end

    always_comb begin
        evt.bclk_rise = b1 & ~b2;
        evt.bclk_fall = ~b1 & b2;
        evt.wclk      = w1;
        evt.wclk_chg  = w1 ^ w2;
        evt.din       = d1;
    end
endmodule

// File: rtl/aud_sport_rx.sv
module aud_sport_rx
    import aud_sport_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    rise,
    input  logic    wclk,
    input  logic    din,
    input  fmt_e    fmt,
    input  logic    pol,
    output stereo_t pair,
    output logic    valid
);
    logic [SHREG_W-1:0]  sh;
    logic [POS_W-1:0]    nbits;
    logic                wclk_last;
    logic                primed;
    logic                have_left;
    logic [SAMPLE_W-1:0] left_stage;
    logic [SAMPLE_W-1:0] word;
    logic                half_end;
    logic                ended_left;

    assign half_end   = rise && (wclk != wclk_last);
    assign ended_left = chan_is_left(fmt, pol, wclk_last);

    // Pick the word out of the half-frame that just ended
    always_comb begin
        case (fmt)
            FMT_RJ16: word = {sh[15:0], 4'b0};
            FMT_RJ20: word = sh[SAMPLE_W-1:0];
            FMT_LJ20: word = (nbits >= POS_W'(SAMPLE_W))
                             ? SAMPLE_W'(sh >> (nbits - POS_W'(SAMPLE_W)))
                             : SAMPLE_W'(sh);
            default:  word = (nbits >= POS_W'(SAMPLE_W + 1))
                             ? SAMPLE_W'(sh >> (nbits - POS_W'(SAMPLE_W + 1)))
                             : SAMPLE_W'(sh);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh         <= '0;
            nbits      <= '0;
            wclk_last  <= 1'b0;
            primed     <= 1'b0;
            have_left  <= 1'b0;
            left_stage <= '0;
            pair       <= '0;
            valid      <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (rise) begin
                wclk_last <= wclk;
                sh        <= {sh[SHREG_W-2:0], din};
                if (half_end) begin
                    primed <= 1'b1;
                    nbits  <= POS_W'(1);
                    if (primed) begin
                        if (ended_left) begin
                            left_stage <= word;
                            have_left  <= 1'b1;
                        end else if (have_left) begin
                            pair.left  <= left_stage;
                            pair.right <= word;
                            valid      <= 1'b1;
                        end
                    end
                end else if (nbits != POS_MAX) begin
                    nbits <= nbits + POS_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/aud_sport_tx.sv
module aud_sport_tx
    import aud_sport_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fall,
    input  logic             wclk_chg,
    input  logic             wclk,
    input  fmt_e             fmt,
    input  logic             pol,
    input  stereo_t          adc,
    output logic             sdout,
    output logic [POS_W-1:0] pos
);
    stereo_t             held;
    logic                cur_left;
    logic                new_left;
    logic [POS_W-1:0]    rel;
    logic [SAMPLE_W-1:0] cur;

    assign new_left = chan_is_left(fmt, pol, wclk);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos      <= POS_MAX;
            held     <= '0;
            cur_left <= 1'b0;
        end else if (wclk_chg) begin
            pos      <= '0;
            cur_left <= new_left;
            if (new_left) held <= adc;
        end else if (fall && pos != POS_MAX) begin
            pos <= pos + POS_W'(1);
        end
    end

    always_comb begin
        rel   = pos - tx_off(fmt);
        cur   = cur_left ? held.left : held.right;
        sdout = 1'b0;
        if (pos >= tx_off(fmt) && rel < tx_len(fmt))
            sdout = cur[IDX_W'(SAMPLE_W - 1) - rel[IDX_W-1:0]];
    end
endmodule

// File: rtl/aud_sport_top.sv
module aud_sport_top
    import aud_sport_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        bclk_i,
    input  logic        wclk_i,
    input  logic        sdin_i,
    input  logic [1:0]  fmt_i,
    input  logic        lr_pol_i,
    input  logic [19:0] adc_left_i,
    input  logic [19:0] adc_right_i,
    output logic        sdout_o,
    output logic [19:0] dac_left_o,
    output logic [19:0] dac_right_o,
    output logic        dac_valid_o
);
    pin_evt_t         evt;
    stereo_t          rx_pair;
    stereo_t          adc_pair;
    fmt_e             fmt;
    logic [POS_W-1:0] tx_pos;

    assign fmt            = fmt_e'(fmt_i);
    assign adc_pair.left  = adc_left_i;
    assign adc_pair.right = adc_right_i;

    aud_sport_pins pins_i (
        .clk (clk_i), .rst (rst_i),
        .bclk(bclk_i), .wclk(wclk_i), .din(sdin_i),
        .evt (evt)
    );

    aud_sport_rx rx_i (
        .clk (clk_i), .rst (rst_i),
        .rise(evt.bclk_rise), .wclk(evt.wclk), .din(evt.din),
        .fmt (fmt), .pol(lr_pol_i),
        .pair(rx_pair), .valid(dac_valid_o)
    );

    aud_sport_tx tx_i (
        .clk     (clk_i), .rst(rst_i),
        .fall    (evt.bclk_fall), .wclk_chg(evt.wclk_chg), .wclk(evt.wclk),
        .fmt     (fmt), .pol(lr_pol_i),
        .adc     (adc_pair),
        .sdout   (sdout_o), .pos(tx_pos)
    );

    assign dac_left_o  = rx_pair.left;
    assign dac_right_o = rx_pair.right;
endmodule

// File: rtl/aud_sport_chk.sv
module aud_sport_chk (
    input logic        clk,
    input logic        rst,
    input logic [1:0]  fmt,
    input logic        sdout,
    input logic [19:0] dl,
    input logic [19:0] dr,
    input logic        valid,
    input logic [5:0]  tx_pos
);
    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        rst_q |-> (!valid && dl == 20'd0 && dr == 20'd0 && !sdout));

    // R10
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    // R10
    hold_between_chk: assert property (@(posedge clk) disable iff (rst)
        !valid |-> ($stable(dl) && $stable(dr)));

    // R7
    i2s_lead_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (fmt == 2'd3 && tx_pos == 6'd0) |-> !sdout);

    // R12
    tail_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_pos >= 6'd21) |-> !sdout);
endmodule

bind aud_sport_top aud_sport_chk chk_i (
    .clk   (clk_i),
    .rst   (rst_i),
    .fmt   (fmt_i),
    .sdout (sdout_o),
    .dl    (dac_left_o),
    .dr    (dac_right_o),
    .valid (dac_valid_o),
    .tx_pos(tx_pos)
);

// File: tb/aud_sport_top_tb_top.sv
module aud_sport_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bclk = 1'b0, wclk = 1'b0, sdin = 1'b0, pol = 1'b0;
    logic [1:0]  fmt = 2'd0;
    logic [19:0] adc_l = '0, adc_r = '0;
    logic        sdout, valid;
    logic [19:0] dac_l, dac_r;

    int errors = 0;
    int checks = 0;
    logic [39:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;   // 250 MHz

    aud_sport_top dut_i (
        .clk_i(clk), .rst_i(rst), .bclk_i(bclk), .wclk_i(wclk), .sdin_i(sdin),
        .fmt_i(fmt), .lr_pol_i(pol), .adc_left_i(adc_l), .adc_right_i(adc_r),
        .sdout_o(sdout), .dac_left_o(dac_l), .dac_right_o(dac_r), .dac_valid_o(valid)
    );

    // Reference model of the receive direction: every clock, a strobe must
    // match the oldest pair still owed (R10)
    always @(negedge clk) begin
        if (!rst && valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R10 unexpected strobe: got %h_%h expected none", dac_l, dac_r);
            end else begin
                logic [39:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if ({dac_l, dac_r} !== e) begin
                    errors++;
                    $display("FAIL %s pair: got %h_%h expected %h_%h", t, dac_l, dac_r, e[39:20], e[19:0]);
                end
            end
        end
    end

    // Serial input bit for slot k of a half-frame of h slots; outside the
    // window an alternating garbage pattern is sent (R12)
    function automatic logic rx_bit(int f, int h, int k, logic [19:0] w);
        case (f)
            0: if (k >= h - 16) return w[19 - (k - (h - 16))];
            1: if (k >= h - 20) return w[19 - (k - (h - 20))];
            2: if (k < 20) return w[19 - k];
            default: if (k >= 1 && k <= 20) return w[20 - k];
        endcase
        return (k % 2 == 0);
    endfunction

    // Expected serial output for slot k: R6 / R7, zero elsewhere (R12)
    function automatic logic tx_bit(int f, int k, logic [19:0] w);
        int off = (f == 3) ? 1 : 0;
        int len = (f == 0) ? 16 : (f == 3) ? 18 : 20;
        if (k >= off && k - off < len) return w[19 - (k - off)];
        return 1'b0;
    endfunction

    task automatic send_bit(logic wv, logic d, bit chk, logic e, string t);
        @(negedge clk);
        bclk = 1'b0; wclk = wv; sdin = d;
        repeat (4) @(negedge clk);
        if (chk) begin
            checks++;
            if (sdout !== e) begin
                errors++;
                $display("FAIL %s sdout: got %b expected %b", t, sdout, e);
            end
        end
        bclk = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; bclk = 1'b0;
        exp_q.delete(); tag_q.delete();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (valid !== 1'b0 || dac_l !== '0 || dac_r !== '0 || sdout !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset state: got v=%b l=%h r=%h so=%b expected all 0",
                     valid, dac_l, dac_r, sdout);
        end
    endtask

    task automatic run_stream(int f, logic p, int frame_len, int nfr, string rtag);
        int h = frame_len / 2;
        logic lw;
        string ttag;
        fmt = 2'(f); pol = p;
        do_reset();
        lw = (f == 3) ? 1'b0 : !p;   // R8, R5
        ttag = (f == 3) ? "R7" : "R6";
        for (int k = 0; k < h; k++) send_bit(!lw, 1'b0, 1'b0, 1'b0, ttag);
        for (int fr = 0; fr < nfr; fr++) begin
            logic [19:0] dl, dr, al, ar;
            dl = 20'($urandom); dr = 20'($urandom);
            if (f == 0) begin dl[3:0] = '0; dr[3:0] = '0; end
            al = 20'($urandom); ar = 20'($urandom);
            adc_l = al; adc_r = ar;
            exp_q.push_back({dl, dr});
            tag_q.push_back($sformatf("%s fmt=%0d pol=%0d frame=%0d (R8 R9 R12)", rtag, f, p, frame_len));
            for (int k = 0; k < h; k++) begin
                if (k == 3) begin adc_l = ~al; adc_r = ~ar; end  // R11
                send_bit(lw, rx_bit(f, h, k, dl), 1'b1, tx_bit(f, k, al),
                         $sformatf("%s R11 left slot %0d fmt=%0d", ttag, k, f));
            end
            for (int k = 0; k < h; k++)
                send_bit(!lw, rx_bit(f, h, k, dr), 1'b1, tx_bit(f, k, ar),
                         $sformatf("%s R11 right slot %0d fmt=%0d", ttag, k, f));
        end
        send_bit(lw, 1'b0, 1'b0, 1'b0, ttag);
        send_bit(lw, 1'b0, 1'b0, 1'b0, ttag);
        repeat (8) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R10 %s missing strobes: got %0d left over expected 0", rtag, exp_q.size());
        end
    endtask

    bit done = 1'b0;

    initial begin
        run_stream(0, 1'b0, 32, 3, "R2");   // R9 shortest frame
        run_stream(0, 1'b1, 64, 3, "R2");   // R8 inverted polarity
        run_stream(1, 1'b0, 48, 3, "R3");
        run_stream(1, 1'b1, 64, 3, "R3");
        run_stream(2, 1'b0, 64, 3, "R4");
        run_stream(2, 1'b1, 48, 3, "R4");
        run_stream(3, 1'b0, 64, 3, "R5");
        run_stream(3, 1'b1, 48, 3, "R5");   // polarity ignored in I2S
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule